// File: doc/BRIEF.md
# Asynchronous Event Priority Arbiter

At every instruction boundary of a small processor core this block looks at all outstanding asynchronous conditions and picks the single action the core must take before it goes on with the next instruction. The conditions include trap requests from the debug logic, system-management and initialisation requests, external interrupts of several kinds and a DMA hold request. The arbiter also owns the small amount of state that goes with this choice: latched request flags, the NMI self-mask, the accumulated debug-trap bits and a one-instruction shadow that can suppress interrupts and/or debug traps.

The core pulses `bnd_i` at an instruction boundary. In the following cycle the block presents a one-hot action on `act_o`, with a vector on `vec_o` and `vld_o` high. These outputs hold until the core pulses `ack_i`. No further boundary is evaluated while a result waits. Delivering the action (exception entry, mode switch, vector fetch) is done by the core. `pend_o` tells the core whether it needs to call the arbiter at all.

Top module: `evt_arbiter`

## Requirements
- R1: Each accepted `bnd_i` produces, one cycle later, `vld_o`=1 with exactly one bit of `act_o` set. `act_o` and `vec_o` hold until `ack_i`. `vld_o` falls in the cycle after `ack_i`. A `bnd_i` seen while `vld_o`=1 is ignored and consumes no pending request.
- R2: Action bits, from highest to lowest priority: 0 task-switch trap, 1 SMI, 2 INIT, 3 monitor trap, 4 debug trap, 5 preemption timer, 6 NMI window, 7 NMI, 8 interrupt window, 9 maskable INTR, 10 virtual IRQ, 11 DMA hold acknowledge, 12 nothing to do. The lowest-numbered eligible bit wins.
- R3: `smi_i` and `init_i` pulses are latched. A latched request is taken only while its mask input is low and `gate_i` is 1, and taking it clears it. An `init_i` pulse arriving while `init_msk_i` is 1 is dropped.
- R4: When `gate_i` is 0, no action from bits 5 to 11 is issued.
- R5: `inh_req_i` with `inh_msk_i` (bit 0 for interrupts, bit 1 for debug traps) shadows exactly the next evaluated boundary. Interrupt shadowing removes bits 5 to 11. Debug shadowing removes bit 4 and keeps the stored debug bits.
- R6: The debug register is 16 bits wide and is set through `dbg_set_i`. Bit 15 is a task-switch trap, bit 14 is single step, and bits 13:12 are breakpoint hits. Any of bits 15:12 gives action 0 or 4 with vector 1 and clears the register. If the evaluation reaches the debug step with none of them set and no debug shadow, the whole register is cleared.
- R7: With `gate_i`=0 at a boundary, every debug bit except bit 14 is discarded.
- R8: `tf_i`=1 at a boundary that does not issue a debug action sets bit 14, so the next boundary issues action 4.
- R9: A delivered NMI has vector 2. Delivery clears the latched NMI and masks both NMI and NMI window until `nmi_unm_i`. An NMI pulse arriving while masked stays latched.
- R10: Interrupt window, INTR and virtual IRQ need `if_i`=1. INTR carries `intr_vec_i` and virtual IRQ carries `virq_vec_i`. All other actions not named carry vector 0.
- R11: `pend_o` is 1 when the debug register is nonzero, or `dma_i` is 1, or `gate_i` is 1 and any unmasked request remains.
- R12: After reset `vld_o` and `pend_o` are 0, and the latched requests, the NMI mask, the debug bits and the shadow are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bnd_i | input | 1 | instruction boundary strobe |
| ack_i | input | 1 | action accepted by the core |
| gate_i | input | 1 | global interrupt gate |
| if_i | input | 1 | interrupt-enable flag |
| tf_i | input | 1 | single-step trap flag |
| smi_msk_i | input | 1 | SMI mask |
| init_msk_i | input | 1 | INIT mask |
| smi_i | input | 1 | SMI request pulse |
| init_i | input | 1 | INIT request pulse |
| nmi_i | input | 1 | NMI request pulse |
| nmi_unm_i | input | 1 | clear NMI mask (return from NMI handler) |
| mtf_i | input | 1 | monitor trap request level |
| pre_i | input | 1 | preemption timer expired level |
| nmiw_i | input | 1 | NMI window request level |
| iwin_i | input | 1 | interrupt window request level |
| intr_i | input | 1 | maskable interrupt level |
| virq_i | input | 1 | virtual interrupt level |
| dma_i | input | 1 | DMA hold request |
| intr_vec_i | input | VW | vector of maskable interrupt |
| virq_vec_i | input | VW | vector of virtual interrupt |
| dbg_set_i | input | 16 | debug-trap bits to set |
| inh_req_i | input | 1 | start an inhibit shadow |
| inh_msk_i | input | 2 | shadow kind: bit0 interrupts, bit1 debug |
| act_o | output | 13 | one-hot action |
| vec_o | output | VW | action vector |
| vld_o | output | 1 | action valid |
| pend_o | output | 1 | asynchronous work remains |

## Verification
The priority chain is swept over every combination of the level requests together with the gate and interrupt-enable flag. This separates the rank of each external source from the rank of every other, and shows what the gate and the flag remove. Directed sequences then cover the latched requests one at a time and in pairs. They check that the NMI stays blocked between delivery and unmask, and that the shadow covers exactly one boundary. Further cases set debug bits below and above bit 12, with and without the gate, to tell discarding apart from clearing. One sequence holds a result without acknowledging it, to show that a second strobe does not consume the SMI latched meanwhile.

// File: rtl/evt_arbiter.sv
module evt_arbiter #(
  parameter int VW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bnd_i,
  input  logic          ack_i,
  input  logic          gate_i,
  input  logic          if_i,
  input  logic          tf_i,
  input  logic          smi_msk_i,
  input  logic          init_msk_i,
  input  logic          smi_i,
  input  logic          init_i,
  input  logic          nmi_i,
  input  logic          nmi_unm_i,
  input  logic          mtf_i,
  input  logic          pre_i,
  input  logic          nmiw_i,
  input  logic          iwin_i,
  input  logic          intr_i,
  input  logic          virq_i,
  input  logic          dma_i,
  input  logic [VW-1:0] intr_vec_i,
  input  logic [VW-1:0] virq_vec_i,
  input  logic [15:0]   dbg_set_i,
  input  logic          inh_req_i,
  input  logic [1:0]    inh_msk_i,
  output logic [12:0]   act_o,
  output logic [VW-1:0] vec_o,
  output logic          vld_o,
  output logic          pend_o
);
  localparam int NA = 13;

  logic          smi_p, init_p, nmi_p, nmi_m;
  logic [15:0]   dbg, dbg_g, dbg_n;
  logic          inh_v;
  logic [1:0]    inh_m;
  logic [CW-1:0] icnt, inh_c, icnt_n;
  logic [NA-1:0] cand, sel;
  logic [VW-1:0] vec_n;

  wire eval     = bnd_i & ~vld_o;
  wire inh_live = inh_v && (icnt <= inh_c);
  wire inh_int  = inh_live & inh_m[0];
  wire inh_dbg  = inh_live & inh_m[1];
  wire ext_ok   = gate_i & ~inh_int;
  wire [15:0] dbg_in = dbg | dbg_set_i;

  assign dbg_g  = gate_i ? dbg_in : (dbg_in & 16'h4000);
  assign icnt_n = icnt + {{(CW-1){1'b0}}, eval};

  assign cand[0]  = dbg_g[15];
  assign cand[1]  = smi_p & ~smi_msk_i & gate_i;
  assign cand[2]  = init_p & ~init_msk_i & gate_i;
  assign cand[3]  = mtf_i;
  assign cand[4]  = ~inh_dbg & (|dbg_g[15:12]);
  assign cand[5]  = ext_ok & pre_i;
  assign cand[6]  = ext_ok & nmiw_i & ~nmi_m;
  assign cand[7]  = ext_ok & nmi_p & ~nmi_m;
  assign cand[8]  = ext_ok & iwin_i & if_i;
  assign cand[9]  = ext_ok & intr_i & if_i;
  assign cand[10] = ext_ok & virq_i & if_i;
  assign cand[11] = ext_ok & dma_i;
  assign cand[12] = 1'b1;
  assign sel = cand & (~cand + {{(NA-1){1'b0}}, 1'b1});

  always_comb begin
    dbg_n = dbg_g;
    if (sel[0] | sel[4]) dbg_n = '0;
    else begin
      if (~inh_dbg & ~(sel[1] | sel[2] | sel[3])) dbg_n = '0;
      if (tf_i) dbg_n[14] = 1'b1;
    end
    vec_n = '0;
    if (sel[0] | sel[4]) vec_n = VW'(1);
    if (sel[7])          vec_n = VW'(2);
    if (sel[9])          vec_n = intr_vec_i;
    if (sel[10])         vec_n = virq_vec_i;
  end

  assign pend_o = (|dbg) | dma_i |
                  (gate_i & ((smi_p & ~smi_msk_i) | (init_p & ~init_msk_i) | mtf_i | pre_i |
                             ((nmiw_i | nmi_p) & ~nmi_m) | ((iwin_i | intr_i | virq_i) & if_i)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smi_p <= 1'b0; init_p <= 1'b0; nmi_p <= 1'b0; nmi_m <= 1'b0;
      dbg   <= '0;   inh_v  <= 1'b0; inh_m <= '0;   inh_c <= '0;
      icnt  <= '0;   vld_o  <= 1'b0; act_o <= '0;   vec_o <= '0;
    end else begin
      icnt <= icnt_n;
      dbg  <= eval ? dbg_n : dbg_in;

      if (eval && sel[1]) smi_p <= 1'b0;
      if (smi_i)          smi_p <= 1'b1;
      if (eval && sel[2]) init_p <= 1'b0;
      if (init_i && !init_msk_i) init_p <= 1'b1;
      if (eval && sel[7]) nmi_p <= 1'b0;
      if (nmi_i)          nmi_p <= 1'b1;
      if (nmi_unm_i)      nmi_m <= 1'b0;
      if (eval && sel[7]) nmi_m <= 1'b1;

      if (inh_req_i) begin
        inh_v <= 1'b1;
        inh_m <= inh_msk_i;
        inh_c <= icnt_n;
      end else if (eval && icnt >= inh_c) begin
        inh_v <= 1'b0;
      end

      if (eval) begin
        vld_o <= 1'b1;
        act_o <= sel;
        vec_o <= vec_n;
      end else if (ack_i) begin
        vld_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/evt_arbiter_chk.sv
module evt_arbiter_chk #(
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bnd_i,
  input logic          ack_i,
  input logic          gate_i,
  input logic [12:0]   act_o,
  input logic [VW-1:0] vec_o,
  input logic          vld_o
);
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $countones(act_o) == 1); // R1
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_i && !vld_o |=> vld_o); // R1
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && !ack_i |=> vld_o && $stable(act_o) && $stable(vec_o)); // R1
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && ack_i |=> !vld_o); // R1
  AST_GATE_BLOCKS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_o) && !$past(gate_i) |-> act_o[11:5] == 7'd0 && act_o[2:1] == 2'd0); // R4
  AST_DB_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && (act_o[0] || act_o[4]) |-> vec_o == VW'(1)); // R6
  AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && act_o[7] |-> vec_o == VW'(2)); // R9
endmodule

bind evt_arbiter evt_arbiter_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bnd_i(bnd_i), .ack_i(ack_i), .gate_i(gate_i),
  .act_o(act_o), .vec_o(vec_o), .vld_o(vld_o)
);

// File: tb/evt_arbiter_test.sv
module evt_arbiter_test;
  logic clk = 0, rst_n = 0;
  logic bnd_i = 0, ack_i = 0, gate_i = 1, if_i = 0, tf_i = 0;
  logic smi_msk_i = 0, init_msk_i = 0, smi_i = 0, init_i = 0, nmi_i = 0, nmi_unm_i = 0;
  logic mtf_i = 0, pre_i = 0, nmiw_i = 0, iwin_i = 0, intr_i = 0, virq_i = 0, dma_i = 0;
  logic [7:0] intr_vec_i = 8'h41, virq_vec_i = 8'h77;
  logic [15:0] dbg_set_i = 0;
  logic inh_req_i = 0;
  logic [1:0] inh_msk_i = 0;
  logic [12:0] act_o;
  logic [7:0] vec_o;
  logic vld_o, pend_o;
  int total = 0, bad = 0;
  logic [12:0] a;
  logic [7:0] v;

  always #10 clk = ~clk;

  evt_arbiter uut (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic boundary(output logic [12:0] ra, output logic [7:0] rv);
    @(negedge clk) bnd_i = 1;
    @(negedge clk) bnd_i = 0;
    ra = act_o; rv = vec_o;
    check("R1 valid", vld_o, 1);
    ack_i = 1;
    @(negedge clk) ack_i = 0;
    check("R1 drop", vld_o, 0);
  endtask

  task automatic pulse_dbg(input logic [15:0] b);
    @(negedge clk) dbg_set_i = b;
    @(negedge clk) dbg_set_i = 0;
  endtask

  task automatic inhibit(input logic [1:0] m);
    @(negedge clk) begin inh_req_i = 1; inh_msk_i = m; end
    @(negedge clk) inh_req_i = 0;
  endtask

  function automatic logic [12:0] bit_of(input int i);
    return 13'd1 << i;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog got=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R12 vld", vld_o, 0);
    check("R12 pend", pend_o, 0);

    // R2 R4 R10 sweep of level sources
    for (int k = 0; k < 512; k++) begin
      int e;
      logic [7:0] ev;
      logic ep;
      {gate_i, if_i, mtf_i, pre_i, nmiw_i, iwin_i, intr_i, virq_i, dma_i} = 9'(k);
      e = 12;
      if (gate_i) begin
        if (dma_i) e = 11;
        if (virq_i && if_i) e = 10;
        if (intr_i && if_i) e = 9;
        if (iwin_i && if_i) e = 8;
        if (nmiw_i) e = 6;
        if (pre_i) e = 5;
      end
      if (mtf_i) e = 3;
      ev = (e == 9) ? intr_vec_i : (e == 10) ? virq_vec_i : 8'h0;
      ep = dma_i | (gate_i & (mtf_i | pre_i | nmiw_i | ((iwin_i | intr_i | virq_i) & if_i)));
      @(negedge clk);
      check("R11 pend sweep", pend_o, ep);
      boundary(a, v);
      check("R2 sweep act", a, bit_of(e));
      check("R10 sweep vec", v, ev);
    end
    {gate_i, if_i, mtf_i, pre_i, nmiw_i, iwin_i, intr_i, virq_i, dma_i} = 9'h100;

    // R3 SMI masked then unmasked, SMI before INIT
    smi_msk_i = 1;
    @(negedge clk) begin smi_i = 1; init_i = 1; end
    @(negedge clk) begin smi_i = 0; init_i = 0; end
    boundary(a, v); check("R3 init while smi masked", a, bit_of(2));
    boundary(a, v); check("R3 smi masked", a, bit_of(12));
    check("R11 masked smi no pend", pend_o, 0);
    smi_msk_i = 0;
    @(negedge clk) check("R11 smi pend", pend_o, 1);
    boundary(a, v); check("R3 smi taken", a, bit_of(1));
    boundary(a, v); check("R3 smi cleared", a, bit_of(12));
    @(negedge clk) begin smi_i = 1; init_i = 1; end
    @(negedge clk) begin smi_i = 0; init_i = 0; end
    gate_i = 0;
    boundary(a, v); check("R3 gate holds smi", a, bit_of(12));
    gate_i = 1;
    boundary(a, v); check("R2 smi over init", a, bit_of(1));
    boundary(a, v); check("R3 init after smi", a, bit_of(2));
    init_msk_i = 1;
    @(negedge clk) init_i = 1;
    @(negedge clk) init_i = 0;
    init_msk_i = 0;
    boundary(a, v); check("R3 init dropped while masked", a, bit_of(12));

    // R9 NMI self-mask
    @(negedge clk) nmi_i = 1;
    @(negedge clk) nmi_i = 0;
    boundary(a, v); check("R9 nmi act", a, bit_of(7)); check("R9 nmi vec", v, 2);
    @(negedge clk) nmi_i = 1;
    @(negedge clk) nmi_i = 0;
    nmiw_i = 1;
    boundary(a, v); check("R9 nmi and window masked", a, bit_of(12));
    nmiw_i = 0;
    @(negedge clk) nmi_unm_i = 1;
    @(negedge clk) nmi_unm_i = 0;
    boundary(a, v); check("R9 latched nmi after unmask", a, bit_of(7));
    @(negedge clk) nmi_unm_i = 1;
    @(negedge clk) nmi_unm_i = 0;

    // R6 debug bits
    pulse_dbg(16'h2000);
    boundary(a, v); check("R6 breakpoint db", a, bit_of(4)); check("R6 db vec", v, 1);
    pulse_dbg(16'h0008);
    check("R11 low dbg pend", pend_o, 1);
    boundary(a, v); check("R6 low bit no db", a, bit_of(12));
    check("R6 low bit cleared", pend_o, 0);
    if_i = 1; intr_i = 1;
    pulse_dbg(16'h8000);
    boundary(a, v); check("R6 task switch first", a, bit_of(0)); check("R6 ts vec", v, 1);
    boundary(a, v); check("R10 intr after ts", a, bit_of(9)); check("R10 intr vec", v, 8'h41);

    // R5 interrupt shadow covers one boundary
    inhibit(2'b01);
    boundary(a, v); check("R5 intr shadowed", a, bit_of(12));
    boundary(a, v); check("R5 shadow over", a, bit_of(9));
    // R5 debug shadow
    pulse_dbg(16'h1000);
    inhibit(2'b10);
    boundary(a, v); check("R5 db shadowed", a, bit_of(9));
    boundary(a, v); check("R5 db kept", a, bit_of(4));
    intr_i = 0; if_i = 0;

    // R7 gate discard vs clear
    pulse_dbg(16'h2000);
    inhibit(2'b10);
    gate_i = 0;
    boundary(a, v); check("R7 gated boundary", a, bit_of(12));
    check("R7 bit discarded", pend_o, 0);
    gate_i = 1;
    boundary(a, v); check("R7 no db later", a, bit_of(12));
    pulse_dbg(16'h4000);
    gate_i = 0;
    boundary(a, v); check("R7 single step kept", a, bit_of(4));
    gate_i = 1;

    // R8 trap flag
    tf_i = 1;
    boundary(a, v); check("R8 tf boundary", a, bit_of(12));
    tf_i = 0;
    check("R8 tf pend", pend_o, 1);
    boundary(a, v); check("R8 step trap", a, bit_of(4));

    // R1 strobe ignored while result waits
    @(negedge clk) bnd_i = 1;
    @(negedge clk) bnd_i = 0;
    check("R1 held act", act_o, bit_of(12));
    @(negedge clk) smi_i = 1;
    @(negedge clk) begin smi_i = 0; bnd_i = 1; end
    @(negedge clk) bnd_i = 0;
    check("R1 strobe ignored", act_o, bit_of(12));
    check("R1 still valid", vld_o, 1);
    ack_i = 1;
    @(negedge clk) ack_i = 0;
    boundary(a, v); check("R1 smi not consumed", a, bit_of(1));

    // R12 reset clears latched state
    @(negedge clk) nmi_i = 1;
    @(negedge clk) begin nmi_i = 0; rst_n = 0; end
    pulse_dbg(16'h0000);
    @(negedge clk) rst_n = 1;
    @(negedge clk) check("R12 pend after reset", pend_o, 0);
    boundary(a, v); check("R12 nmi cleared", a, bit_of(12));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule